// File: doc/BRIEF.md
# Tag-Ordered Transfer Command Queue

This block queues block-transfer commands and releases them to a bus engine as transfers of at most 128 bytes. Each command names a local address, an external address, a byte count and a 5-bit tag group. It may also carry an ordering modifier. The modifier is either a fence, which holds that one command behind its elder group mates, or a barrier, which holds the command and all younger group mates. A separate sync command holds every younger command, of any tag, until all of its elders have drained. Commands that are free to go may overtake commands of other groups. Among the commands that may go, the eldest goes first.

Completions come back as a plain pulse that carries the slot index the transfer was issued with. A command leaves the queue once all of its transfers have completed. A status port reports which tag groups are idle, restricted to a query mask. It can answer at once, or wait until all of the masked groups are idle, or wait until any one of them is idle.

Back-pressure rules: the command port accepts on `cmd_valid && cmd_ready`, and `cmd_ready` is low whenever the 16 slots are full. The transfer port moves a beat on `bus_valid && bus_ready`, and its payload does not change while `bus_valid` is high and `bus_ready` is low. The status port accepts a query on `qry_valid && qry_ready`.

Top module: `xfer_cmd_queue`

## Requirements
- R1: The queue holds 16 commands. `free_cnt` equals the number of empty slots, and `cmd_ready` is low exactly when `free_cnt` is 0.
- R2: A non-sync command whose size is 0, is not a multiple of 16, or exceeds 16384 is dropped. `cmd_err` is high in the cycle after its handshake, and `free_cnt` does not fall.
- R3: A command is sent as transfers of min(remaining, 128) bytes, in ascending order. Local and external addresses advance by the length of each transfer, and the lengths of all transfers sum to the command size.
- R4: No more than 16 transfers are outstanding. A transfer counts as outstanding from the time it is loaded onto the transfer port until its completion pulse.
- R5: A fenced command (`cmd_fence`=1) starts no transfer while an elder command of the same tag is still queued. Younger unfenced commands of that tag are not held by it.
- R6: A barrier command (`cmd_barrier`=1), and every younger command of its tag, starts nothing while commands of that tag that are older than the barrier remain queued.
- R7: A sync command (`cmd_sync`=1, other fields ignored) occupies a slot and issues no transfer. It holds all younger commands until every elder command has left, and then it leaves.
- R8: Commands that are not held may start ahead of commands of other tags. When several commands are eligible, the transfer comes from the eldest.
- R9: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_la`, `bus_ea`, `bus_len` and `bus_id` hold their values.
- R10: A tag group is busy while any non-sync command with that tag occupies a slot. Mode 0 (and mode 3) answers with `stat_valid` in the cycle after the query, with `stat_data` = mask AND NOT busy.
- R11: Mode 1 answers once every masked group is idle. `stat_data` is then the mask.
- R12: Mode 2 answers once at least one masked group is idle (or at once if the mask is 0), with `stat_data` = mask AND NOT busy.
- R13: While a conditional query waits, `qry_ready` is low. `stat_valid` is raised only in response to a query.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | A slot is free |
| cmd_la | input | 18 | Local start address |
| cmd_ea | input | 32 | External start address |
| cmd_size | input | 15 | Byte count |
| cmd_tag | input | 5 | Tag group |
| cmd_fence | input | 1 | Fence modifier |
| cmd_barrier | input | 1 | Barrier modifier |
| cmd_sync | input | 1 | Standalone all-tag barrier |
| cmd_err | output | 1 | Last accepted command was rejected |
| free_cnt | output | 5 | Number of empty slots |
| bus_valid | output | 1 | Transfer offered |
| bus_ready | input | 1 | Transfer taken |
| bus_la | output | 18 | Transfer local address |
| bus_ea | output | 32 | Transfer external address |
| bus_len | output | 8 | Transfer length in bytes |
| bus_id | output | 4 | Slot index, echoed on completion |
| done_valid | input | 1 | One transfer completed |
| done_id | input | 4 | Slot index of the completed transfer |
| qry_valid | input | 1 | Status query offered |
| qry_ready | output | 1 | No query waiting |
| qry_mode | input | 2 | 0 now, 1 all, 2 any, 3 now |
| qry_mask | input | 32 | Groups of interest |
| stat_valid | output | 1 | Status answer pulse |
| stat_data | output | 32 | Idle masked groups |

## Verification
An accepted command occupies its slot at the next edge, so `free_cnt` falls one cycle after the handshake. The first transfer of a command appears on the transfer port one cycle after that, and `cmd_err` is high in the cycle right after a rejected handshake. A completion pulse clears the in-flight count at its edge, and the slot is freed one edge later, so a waiting status answer arrives two cycles after the last completion. An immediate answer comes one cycle after the query. The bench drives inputs and samples outputs at the falling edge. It latches the single-cycle status pulse as it happens, and every wait for a later event is a bounded loop, so a result that comes too late or never is reported as a failed check.

// File: rtl/xq_pkg.sv
`timescale 1ns/1ps
package xq_pkg;
  localparam int TAG_W = 5;
  localparam int NTAG  = 1 << TAG_W;

  typedef enum logic [1:0] {
    QM_NOW = 2'd0,
    QM_ALL = 2'd1,
    QM_ANY = 2'd2,
    QM_RSV = 2'd3
  } qmode_e;
endpackage

// File: rtl/xq_age.sv
`timescale 1ns/1ps
// Age matrix: older[i][j] is set when slot j was filled before slot i.
module xq_age #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alloc_en,
  input  logic [IW-1:0]       alloc_idx,
  input  logic [N-1:0]        vld,
  input  logic [N-1:0]        free_vec,
  input  logic [N-1:0]        req,
  output logic [N-1:0][N-1:0] older,
  output logic [N-1:0]        gnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      older <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          if (alloc_en && alloc_idx == IW'(i))
            older[i][j] <= vld[j] & ~free_vec[j];
          else if (free_vec[j])
            older[i][j] <= 1'b0;
        end
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_pick
    assign gnt[g] = req[g] & ~|(older[g] & req);
  end
endmodule

// File: rtl/xq_tagstat.sv
`timescale 1ns/1ps
// Tag-group status responder: immediate, wait-all and wait-any.
module xq_tagstat
  import xq_pkg::*;
#(
  parameter int NT = NTAG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] busy,
  input  logic          qry_valid,
  output logic          qry_ready,
  input  logic [1:0]    qry_mode,
  input  logic [NT-1:0] qry_mask,
  output logic          stat_valid,
  output logic [NT-1:0] stat_data
);
  logic          pend;
  logic [1:0]    mode_q;
  logic [NT-1:0] mask_q;
  logic [NT-1:0] eff_mask, idle_m;
  qmode_e        eff_mode;
  logic          met, active;

  assign qry_ready = ~pend;
  assign eff_mask  = pend ? mask_q : qry_mask;
  assign eff_mode  = qmode_e'(pend ? mode_q : qry_mode);
  assign idle_m    = ~busy & eff_mask;
  assign active    = pend | qry_valid;

  always_comb begin
    case (eff_mode)
      QM_ALL:  met = (idle_m == eff_mask);
      QM_ANY:  met = (eff_mask == '0) | (|idle_m);
      default: met = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      mode_q     <= '0;
      mask_q     <= '0;
      stat_valid <= 1'b0;
      stat_data  <= '0;
    end else begin
      stat_valid <= 1'b0;
      if (active && met) begin
        stat_valid <= 1'b1;
        stat_data  <= idle_m;
        pend       <= 1'b0;
      end else if (qry_valid && !pend) begin
        pend   <= 1'b1;
        mode_q <= qry_mode;
        mask_q <= qry_mask;
      end
    end
  end
endmodule

// File: rtl/xfer_cmd_queue.sv
`timescale 1ns/1ps
module xfer_cmd_queue
  import xq_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int LA_W     = 18,
  parameter int EA_W     = 32,
  parameter int MAX_SIZE = 16384,
  parameter int GRAN     = 16,
  parameter int XFER_B   = 128,
  parameter int MAX_OUT  = 16,
  localparam int SZ_W  = $clog2(MAX_SIZE + 1),
  localparam int LEN_W = $clog2(XFER_B + 1),
  localparam int IDX_W = $clog2(DEPTH),
  localparam int FC_W  = $clog2(DEPTH + 1),
  localparam int CNT_W = $clog2(MAX_OUT + 1),
  localparam int GB    = $clog2(GRAN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [LA_W-1:0]  cmd_la,
  input  logic [EA_W-1:0]  cmd_ea,
  input  logic [SZ_W-1:0]  cmd_size,
  input  logic [TAG_W-1:0] cmd_tag,
  input  logic             cmd_fence,
  input  logic             cmd_barrier,
  input  logic             cmd_sync,
  output logic             cmd_err,
  output logic [FC_W-1:0]  free_cnt,
  output logic             bus_valid,
  input  logic             bus_ready,
  output logic [LA_W-1:0]  bus_la,
  output logic [EA_W-1:0]  bus_ea,
  output logic [LEN_W-1:0] bus_len,
  output logic [IDX_W-1:0] bus_id,
  input  logic             done_valid,
  input  logic [IDX_W-1:0] done_id,
  input  logic             qry_valid,
  output logic             qry_ready,
  input  logic [1:0]       qry_mode,
  input  logic [NTAG-1:0]  qry_mask,
  output logic             stat_valid,
  output logic [NTAG-1:0]  stat_data
);
  // slot state
  logic [DEPTH-1:0] v, syn, fen, bar;
  logic [TAG_W-1:0] tag  [DEPTH];
  logic [LA_W-1:0]  la   [DEPTH];
  logic [EA_W-1:0]  ea   [DEPTH];
  logic [SZ_W-1:0]  rem  [DEPTH];
  logic [CNT_W-1:0] infl [DEPTH];
  logic [CNT_W-1:0] out_cnt;

  logic [DEPTH-1:0][DEPTH-1:0] older;
  logic [DEPTH-1:0] gate, osync, bblk, req, gnt, retire;
  logic [NTAG-1:0]  busy;

  // ---------------- intake ----------------
  logic             acc, size_ok, enq;
  logic [IDX_W-1:0] fslot;

  assign cmd_ready = ~&v;
  assign free_cnt  = FC_W'(DEPTH) - FC_W'($countones(v));
  assign size_ok   = (cmd_size != '0) && (cmd_size[GB-1:0] == '0) &&
                     (cmd_size <= SZ_W'(MAX_SIZE));
  assign acc       = cmd_valid & cmd_ready;
  assign enq       = acc & (cmd_sync | size_ok);

  always_comb begin
    fslot = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!v[i]) fslot = IDX_W'(i);
  end

  // ---------------- ordering rules per slot ----------------
  for (genvar g = 0; g < DEPTH; g++) begin : g_rule
    logic [DEPTH-1:0] same_old;
    always_comb begin
      for (int j = 0; j < DEPTH; j++)
        same_old[j] = v[j] & ~syn[j] & older[g][j] & (tag[j] == tag[g]);
    end
    assign gate[g]   = |same_old;
    assign osync[g]  = |(older[g] & v & syn);
    assign bblk[g]   = |(same_old & bar & gate);
    assign req[g]    = v[g] & ~syn[g] & (rem[g] != '0) &
                       ~((fen[g] | bar[g]) & gate[g]) & ~bblk[g] & ~osync[g];
    assign retire[g] = v[g] & (syn[g] ? ~|(older[g] & v)
                                      : ((rem[g] == '0) && (infl[g] == '0)));
  end

  always_comb begin
    busy = '0;
    for (int i = 0; i < DEPTH; i++)
      if (v[i] && !syn[i]) busy[tag[i]] = 1'b1;
  end

  xq_age #(.N(DEPTH)) u_age (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (enq),
    .alloc_idx (fslot),
    .vld       (v),
    .free_vec  (retire),
    .req       (req),
    .older     (older),
    .gnt       (gnt)
  );

  // ---------------- transfer issue ----------------
  logic             load, slot_free, dn;
  logic [IDX_W-1:0] sel;
  logic [SZ_W-1:0]  chunk;

  always_comb begin
    sel = '0;
    for (int i = 0; i < DEPTH; i++)
      if (gnt[i]) sel = IDX_W'(i);
  end

  assign chunk     = (rem[sel] > SZ_W'(XFER_B)) ? SZ_W'(XFER_B) : rem[sel];
  assign slot_free = ~bus_valid | bus_ready;
  assign load      = slot_free & (|gnt) & (out_cnt < CNT_W'(MAX_OUT));
  assign dn        = done_valid & v[done_id] & (infl[done_id] != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_valid <= 1'b0;
      bus_la    <= '0;
      bus_ea    <= '0;
      bus_len   <= '0;
      bus_id    <= '0;
      out_cnt   <= '0;
      cmd_err   <= 1'b0;
    end else begin
      cmd_err <= acc & ~cmd_sync & ~size_ok;
      out_cnt <= out_cnt + CNT_W'(load) - CNT_W'(dn);
      if (load) begin
        bus_valid <= 1'b1;
        bus_la    <= la[sel];
        bus_ea    <= ea[sel];
        bus_len   <= LEN_W'(chunk);
        bus_id    <= sel;
      end else if (bus_ready) begin
        bus_valid <= 1'b0;
      end
    end
  end

  // ---------------- slot update ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v   <= '0;
      syn <= '0;
      fen <= '0;
      bar <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tag[i]  <= '0;
        la[i]   <= '0;
        ea[i]   <= '0;
        rem[i]  <= '0;
        infl[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (retire[i]) v[i] <= 1'b0;
        if (enq && fslot == IDX_W'(i)) begin
          v[i]    <= 1'b1;
          syn[i]  <= cmd_sync;
          fen[i]  <= cmd_fence & ~cmd_sync;
          bar[i]  <= cmd_barrier & ~cmd_sync;
          tag[i]  <= cmd_tag;
          la[i]   <= cmd_la;
          ea[i]   <= cmd_ea;
          rem[i]  <= cmd_sync ? '0 : cmd_size;
          infl[i] <= '0;
        end else if (v[i]) begin
          if (load && sel == IDX_W'(i)) begin
            rem[i] <= rem[i] - chunk;
            la[i]  <= la[i] + LA_W'(chunk);
            ea[i]  <= ea[i] + EA_W'(chunk);
          end
          infl[i] <= infl[i] + CNT_W'(load && sel == IDX_W'(i))
                             - CNT_W'(dn && done_id == IDX_W'(i));
        end
      end
    end
  end

  // ---------------- status ----------------
  xq_tagstat #(.NT(NTAG)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .qry_valid  (qry_valid),
    .qry_ready  (qry_ready),
    .qry_mode   (qry_mode),
    .qry_mask   (qry_mask),
    .stat_valid (stat_valid),
    .stat_data  (stat_data)
  );
endmodule

// File: rtl/xq_chk.sv
`timescale 1ns/1ps
module xq_chk #(
  parameter int LA_W     = 18,
  parameter int EA_W     = 32,
  parameter int MAX_SIZE = 16384,
  parameter int XFER_B   = 128,
  parameter int MAX_OUT  = 16,
  parameter int SZ_W     = 15,
  parameter int LEN_W    = 8,
  parameter int IDX_W    = 4,
  parameter int FC_W     = 5,
  parameter int CNT_W    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [SZ_W-1:0]  cmd_size,
  input logic             cmd_sync,
  input logic             cmd_err,
  input logic [FC_W-1:0]  free_cnt,
  input logic             bus_valid,
  input logic             bus_ready,
  input logic [LA_W-1:0]  bus_la,
  input logic [EA_W-1:0]  bus_ea,
  input logic [LEN_W-1:0] bus_len,
  input logic [IDX_W-1:0] bus_id,
  input logic [CNT_W-1:0] out_cnt,
  input logic             qry_valid,
  input logic             qry_ready,
  input logic             stat_valid
);
  logic bad_sz;
  assign bad_sz = (cmd_size == '0) || (cmd_size[3:0] != 4'd0) ||
                  (cmd_size > SZ_W'(MAX_SIZE));

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (free_cnt == '0) |-> !cmd_ready) else $error("full queue ready"); // R1

  AST_BAD_SIZE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !cmd_sync && bad_sz) |=> cmd_err) else $error("no err"); // R2

  AST_XFER_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_len != '0) && (bus_len <= LEN_W'(XFER_B)) && (bus_len[3:0] == 4'd0))
    else $error("bad length"); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_cnt <= CNT_W'(MAX_OUT)) else $error("too many outstanding"); // R4

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> bus_valid && $stable(bus_la) && $stable(bus_ea) &&
    $stable(bus_len) && $stable(bus_id)) else $error("payload moved"); // R9

  AST_STAT_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> $past(qry_valid || !qry_ready)) else $error("unrequested status"); // R13
endmodule

bind xfer_cmd_queue xq_chk #(
  .LA_W(LA_W), .EA_W(EA_W), .MAX_SIZE(MAX_SIZE), .XFER_B(XFER_B), .MAX_OUT(MAX_OUT),
  .SZ_W(SZ_W), .LEN_W(LEN_W), .IDX_W(IDX_W), .FC_W(FC_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_size(cmd_size), .cmd_sync(cmd_sync), .cmd_err(cmd_err), .free_cnt(free_cnt),
  .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_la(bus_la), .bus_ea(bus_ea),
  .bus_len(bus_len), .bus_id(bus_id), .out_cnt(out_cnt), .qry_valid(qry_valid),
  .qry_ready(qry_ready), .stat_valid(stat_valid)
);

// File: tb/tb_xfer_cmd_queue.sv
`timescale 1ns/1ps
module tb_xfer_cmd_queue;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_ready, cmd_fence, cmd_barrier, cmd_sync, cmd_err;
  logic [17:0] cmd_la;
  logic [31:0] cmd_ea;
  logic [14:0] cmd_size;
  logic [4:0]  cmd_tag;
  logic [4:0]  free_cnt;
  logic        bus_valid, bus_ready;
  logic [17:0] bus_la;
  logic [31:0] bus_ea;
  logic [7:0]  bus_len;
  logic [3:0]  bus_id;
  logic        done_valid;
  logic [3:0]  done_id;
  logic        qry_valid, qry_ready, stat_valid;
  logic [1:0]  qry_mode;
  logic [31:0] qry_mask, stat_data;

  always #2.5 clk = ~clk;

  xfer_cmd_queue dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_la(cmd_la), .cmd_ea(cmd_ea), .cmd_size(cmd_size), .cmd_tag(cmd_tag),
    .cmd_fence(cmd_fence), .cmd_barrier(cmd_barrier), .cmd_sync(cmd_sync),
    .cmd_err(cmd_err), .free_cnt(free_cnt), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_la(bus_la), .bus_ea(bus_ea), .bus_len(bus_len), .bus_id(bus_id),
    .done_valid(done_valid), .done_id(done_id), .qry_valid(qry_valid),
    .qry_ready(qry_ready), .qry_mode(qry_mode), .qry_mask(qry_mask),
    .stat_valid(stat_valid), .stat_data(stat_data)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [31:0] lg_ea [1024];
  logic [17:0] lg_la [1024];
  int          lg_len [1024];
  int          nl = 0;
  logic [3:0]  pend [32];
  int          np = 0;
  bit auto_done = 0, drain_all = 0, rnd_ready = 0, cmd_fire = 0;
  bit st_seen = 0;
  logic [31:0] st_data;

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic step();
    bit d;
    if (rnd_ready) bus_ready = ($urandom_range(0, 3) != 0);
    d = (np > 0) && (drain_all || (auto_done && $urandom_range(0, 2) == 0));
    done_valid = d;
    if (d) begin
      done_id = pend[0];
      for (int k = 0; k < np - 1; k++) pend[k] = pend[k+1];
      np--;
    end
    #1;
    cmd_fire = cmd_valid && cmd_ready;
    if (bus_valid && bus_ready) begin
      lg_ea[nl] = bus_ea; lg_la[nl] = bus_la; lg_len[nl] = int'(bus_len); nl++;
      pend[np] = bus_id; np++;
    end
    @(posedge clk);
    @(negedge clk);
    done_valid = 0;
    if (stat_valid) begin st_seen = 1; st_data = stat_data; end
  endtask

  task automatic send_cmd(input logic [17:0] la, input logic [31:0] ea, input int sz,
                          input int tg, input bit f, input bit b, input bit s, output bit err);
    cmd_la = la; cmd_ea = ea; cmd_size = 15'(sz); cmd_tag = 5'(tg);
    cmd_fence = f; cmd_barrier = b; cmd_sync = s; cmd_valid = 1;
    for (int k = 0; k < 200; k++) begin
      step();
      if (cmd_fire) break;
    end
    cmd_valid = 0;
    err = cmd_err;
  endtask

  task automatic release_all();
    drain_all = 1;
    for (int k = 0; k < 100 && np > 0; k++) step();
    drain_all = 0;
  endtask

  task automatic wait_idle(input string rq);
    bit save_ready;
    save_ready = bus_ready;
    auto_done = 1; bus_ready = 1;
    for (int k = 0; k < 5000; k++) begin
      if (free_cnt == 5'd16 && np == 0 && !bus_valid) break;
      step();
    end
    check(free_cnt == 5'd16, rq, "drain free_cnt", free_cnt, 16);
    auto_done = 0; bus_ready = save_ready;
  endtask

  task automatic do_qry(input int mode, input logic [31:0] mask);
    st_seen = 0; qry_valid = 1; qry_mode = 2'(mode); qry_mask = mask;
    step();
    qry_valid = 0;
  endtask

  function automatic bit seen(input logic [31:0] a, input int from);
    for (int k = from; k < nl; k++) if (lg_ea[k] == a) return 1;
    return 0;
  endfunction

  function automatic int sum_len(input int from);
    int s = 0;
    for (int k = from; k < nl; k++) s += lg_len[k];
    return s;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #900000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
    summary();
  end

  initial begin
    bit e;
    int mark, exp_bytes, bad_len;
    void'($urandom(32'd20240611));
    rst_n = 0; cmd_valid = 0; cmd_la = 0; cmd_ea = 0; cmd_size = 0; cmd_tag = 0;
    cmd_fence = 0; cmd_barrier = 0; cmd_sync = 0; bus_ready = 0; done_valid = 0;
    done_id = 0; qry_valid = 0; qry_mode = 0; qry_mask = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // reset state
    check(cmd_ready == 1, "R1", "reset ready", cmd_ready, 1);
    check(free_cnt == 16, "R1", "reset free_cnt", free_cnt, 16);
    check(bus_valid == 0, "R9", "reset bus_valid", bus_valid, 0);
    check(qry_ready == 1 && stat_valid == 0, "R13", "reset status port", stat_valid, 0);

    // R3 / R8: splitting and eldest-first
    mark = nl;
    send_cmd(18'h100, 32'h1000, 256, 1, 0, 0, 0, e);
    send_cmd(18'h400, 32'h8000, 48, 2, 0, 0, 0, e);
    check(free_cnt == 14, "R1", "two queued", free_cnt, 14);
    bus_ready = 1;
    repeat (8) step();
    check(nl - mark == 3, "R3", "transfer count", nl - mark, 3);
    check(lg_ea[mark] == 32'h1000 && lg_len[mark] == 128, "R3", "first beat", lg_ea[mark], 32'h1000);
    check(lg_ea[mark+1] == 32'h1080 && lg_la[mark+1] == 18'h180, "R3", "second beat addr", lg_ea[mark+1], 32'h1080);
    check(lg_ea[mark+2] == 32'h8000 && lg_len[mark+2] == 48, "R8", "eldest first then other tag", lg_ea[mark+2], 32'h8000);
    wait_idle("R1");

    // R2: size validation
    bus_ready = 0;
    send_cmd(18'h0, 32'h0, 20, 0, 0, 0, 0, e);
    check(e == 1 && free_cnt == 16, "R2", "size 20 rejected", e, 1);
    send_cmd(18'h0, 32'h0, 16400, 0, 0, 0, 0, e);
    check(e == 1 && free_cnt == 16, "R2", "size 16400 rejected", e, 1);
    send_cmd(18'h0, 32'h0, 0, 0, 0, 0, 0, e);
    check(e == 1 && free_cnt == 16, "R2", "size 0 rejected", e, 1);
    send_cmd(18'h0, 32'h20000, 16384, 0, 0, 0, 0, e);
    check(e == 0 && free_cnt == 15, "R2", "size 16384 accepted", free_cnt, 15);
    send_cmd(18'h0, 32'h90000, 16, 0, 0, 0, 0, e);
    check(e == 0 && free_cnt == 14, "R2", "size 16 accepted", free_cnt, 14);
    wait_idle("R2");

    // R1 / R9: full queue and held payload
    bus_ready = 0; auto_done = 0;
    for (int k = 0; k < 16; k++) send_cmd(18'(k * 16), 32'h40000 + 32'(k * 16), 16, 9, 0, 0, 0, e);
    check(free_cnt == 0 && cmd_ready == 0, "R1", "full", free_cnt, 0);
    begin
      logic [31:0] hold_ea;
      hold_ea = bus_ea;
      cmd_valid = 1; cmd_size = 15'd16; cmd_sync = 0;
      repeat (3) begin
        step();
        check(!cmd_fire, "R1", "no accept when full", cmd_fire, 0);
      end
      cmd_valid = 0;
      check(bus_valid && bus_ea == hold_ea, "R9", "payload held", bus_ea, hold_ea);
    end
    wait_idle("R1");

    // R4: outstanding limit
    auto_done = 0; bus_ready = 1; mark = nl;
    send_cmd(18'h0, 32'h100000, 4096, 3, 0, 0, 0, e);
    repeat (60) step();
    check(nl - mark == 16, "R4", "outstanding capped", nl - mark, 16);
    check(bus_valid == 0, "R4", "no offer at cap", bus_valid, 0);
    wait_idle("R4");
    check(nl - mark == 32, "R3", "all beats of 4096", nl - mark, 32);

    // R5: fence
    bus_ready = 1;
    send_cmd(18'h0, 32'h2000, 128, 2, 0, 0, 0, e);
    repeat (4) step();
    mark = nl;
    send_cmd(18'h0, 32'h3000, 128, 2, 1, 0, 0, e);
    send_cmd(18'h0, 32'h4000, 128, 2, 0, 0, 0, e);
    send_cmd(18'h0, 32'h5000, 128, 5, 0, 0, 0, e);
    repeat (8) step();
    check(!seen(32'h3000, mark), "R5", "fenced held", seen(32'h3000, mark), 0);
    check(seen(32'h4000, mark), "R5", "younger unfenced goes", seen(32'h4000, mark), 1);
    check(seen(32'h5000, mark), "R8", "other tag overtakes", seen(32'h5000, mark), 1);
    release_all();
    repeat (8) step();
    check(seen(32'h3000, mark), "R5", "fenced released", seen(32'h3000, mark), 1);
    wait_idle("R5");

    // R6: barrier
    send_cmd(18'h0, 32'h6000, 128, 1, 0, 0, 0, e);
    repeat (4) step();
    mark = nl;
    send_cmd(18'h0, 32'h7000, 128, 1, 0, 1, 0, e);
    send_cmd(18'h0, 32'h7800, 128, 1, 0, 0, 0, e);
    send_cmd(18'h0, 32'h9000, 128, 4, 0, 0, 0, e);
    repeat (8) step();
    check(!seen(32'h7000, mark), "R6", "barrier held", seen(32'h7000, mark), 0);
    check(!seen(32'h7800, mark), "R6", "younger behind barrier held", seen(32'h7800, mark), 0);
    check(seen(32'h9000, mark), "R6", "other tag free", seen(32'h9000, mark), 1);
    release_all();
    repeat (8) step();
    check(seen(32'h7000, mark) && seen(32'h7800, mark), "R6", "barrier released", seen(32'h7800, mark), 1);
    wait_idle("R6");

    // R7: sync
    send_cmd(18'h0, 32'hA000, 128, 1, 0, 0, 0, e);
    repeat (4) step();
    mark = nl;
    send_cmd(18'h0, 32'h0, 0, 0, 0, 0, 1, e);
    check(e == 0, "R7", "sync size ignored", e, 0);
    send_cmd(18'h0, 32'hB000, 128, 6, 0, 0, 0, e);
    repeat (8) step();
    check(!seen(32'hB000, mark), "R7", "held by sync", seen(32'hB000, mark), 0);
    check(free_cnt == 13, "R7", "sync occupies slot", free_cnt, 13);
    release_all();
    repeat (8) step();
    check(seen(32'hB000, mark), "R7", "sync released", seen(32'hB000, mark), 1);
    wait_idle("R7");

    // R10-R13: status
    send_cmd(18'h0, 32'hC000, 128, 1, 0, 0, 0, e);
    repeat (4) step();
    do_qry(0, 32'h82);
    check(st_seen && st_data == 32'h80, "R10", "immediate", st_data, 32'h80);
    do_qry(3, 32'h82);
    check(st_seen && st_data == 32'h80, "R10", "mode 3 immediate", st_data, 32'h80);
    do_qry(2, 32'h82);
    check(st_seen && st_data == 32'h80, "R12", "any with idle group", st_data, 32'h80);
    do_qry(1, 32'h82);
    check(!st_seen && qry_ready == 0, "R13", "all waits", qry_ready, 0);
    repeat (3) step();
    check(!st_seen, "R11", "still waiting", st_seen, 0);
    release_all();
    for (int k = 0; k < 10 && !st_seen; k++) step();
    check(st_seen && st_data == 32'h82, "R11", "all answered", st_data, 32'h82);
    send_cmd(18'h0, 32'hD000, 128, 1, 0, 0, 0, e);
    repeat (4) step();
    do_qry(2, 32'h02);
    check(!st_seen, "R12", "any waits", st_seen, 0);
    release_all();
    for (int k = 0; k < 10 && !st_seen; k++) step();
    check(st_seen && st_data == 32'h02, "R12", "any answered", st_data, 32'h02);
    wait_idle("R10");

    // random traffic
    rnd_ready = 1; auto_done = 1; mark = nl; exp_bytes = 0;
    for (int k = 0; k < 40; k++) begin
      int sz;
      sz = 16 * $urandom_range(1, 32);
      exp_bytes += sz;
      send_cmd(18'($urandom_range(0, 4095) * 16), 32'h200000 + 32'(k * 4096), sz,
               $urandom_range(0, 7), $urandom_range(0, 3) == 0, $urandom_range(0, 7) == 0, 0, e);
    end
    rnd_ready = 0;
    wait_idle("R3");
    check(sum_len(mark) == exp_bytes, "R3", "random byte total", sum_len(mark), exp_bytes);
    bad_len = 0;
    for (int k = mark; k < nl; k++) if (lg_len[k] < 16 || lg_len[k] > 128 || lg_len[k] % 16 != 0) bad_len++;
    check(bad_len == 0, "R3", "random beat lengths", bad_len, 0);
    do_qry(0, 32'hFFFF_FFFF);
    check(st_seen && st_data == 32'hFFFF_FFFF, "R10", "all idle after drain", st_data, 32'hFFFF_FFFF);

    summary();
  end
endmodule